// File: doc/BRIEF.md
# Gated Serial Transmit Path

This block is the transmit side of an asynchronous serial port. Bytes arrive on a write strobe. They are either queued in a transmit FIFO (FIFO mode) or placed straight into a one-byte holding register (non-FIFO mode). A serializer then shifts each byte onto the serial line as a fixed frame: one start bit, eight data bits and one stop bit. Each bit lasts a parameterized number of baud ticks. A baud tick is a one-cycle strobe from an external divisor.

A unit-enable input gates the serializer. Software may queue data while the unit is disabled. The data waits until the unit is enabled. If the unit is disabled during a frame, that frame still runs to its stop bit. After it, no new frame starts. Queued bytes are kept and go out once the unit is enabled again. Writes that find no room are discarded and raise a sticky overflow flag.

Two state machines control the block. The holding register has two states:
- `HR_EMPTY` goes to `HR_FULL` on a load.
- `HR_FULL` goes back to `HR_EMPTY` when the serializer takes the byte and no new byte is loaded in the same cycle.

The serializer has four states:
- `SH_IDLE` goes to `SH_START` when the unit is enabled and the holding register is full. This is the take transition.
- `SH_START` goes to `SH_DATA` after one bit time.
- `SH_DATA` goes to `SH_STOP` after the eighth data bit.
- `SH_STOP` goes back to `SH_IDLE` after one bit time.

Top module: `uart_tx_gated`

## Requirements
- R1: After reset the line is high, `thr_empty`=1, `tx_idle`=1 and `ovf_flag`=0. While `unit_en` is low, no frame starts and the line stays high.
- R2: Bytes written while the unit is disabled are stored, and they are transmitted after `unit_en` is set.
- R3: Each frame is a start bit (0), then eight data bits sent least-significant bit first, then a stop bit (1). Every bit lasts OVS baud ticks. The line idles at 1.
- R4: In FIFO mode (`fifo_mode`=1) each byte passes from the FIFO into the holding register before it is serialized. Bytes leave in write order. The storage holds DEPTH bytes in the FIFO plus one in the holding register.
- R5: If `unit_en` falls during a frame, that frame completes and no further frame starts.
- R6: Disabling the unit does not discard queued bytes. Transmission resumes with the remaining bytes when `unit_en` rises again.
- R7: In FIFO mode, a write while the FIFO holds DEPTH bytes is discarded and sets `ovf_flag`.
- R8: In non-FIFO mode (`fifo_mode`=0) the holding register is the only storage. A write while it is full, and not being taken in that cycle, is discarded and sets `ovf_flag`.
- R9: `ovf_flag` stays set until reset.
- R10: `thr_empty` is 1 exactly when the holding register is empty. `tx_idle` is 1 exactly when the FIFO, the holding register and the serializer are all empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| unit_en | input | 1 | Unit enable |
| fifo_mode | input | 1 | 1: writes go through the FIFO; 0: holding register only |
| baud_tick | input | 1 | One-cycle baud strobe |
| txd | output | 1 | Serial line |
| thr_empty | output | 1 | Holding register empty |
| tx_idle | output | 1 | FIFO, holding register and serializer all empty |
| ovf_flag | output | 1 | Sticky write-overflow flag |

## Verification
The bench builds the block with DEPTH=4 and OVS=4. The small depth lets a burst of five accepted writes, followed by one rejected write, reach the FIFO-full overflow within a few cycles. The short bit time makes each frame 40 cycles long. That keeps disabling the unit mid-frame, waiting, and resuming within a short run, and the frames can still be sampled at bit centres.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_STOP
    } sh_state_t;

    typedef enum logic {
        HR_EMPTY,
        HR_FULL
    } hr_state_t;
endpackage

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   CNT_MAX = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [AW:0]      cnt;
    logic             push_ok, pop_ok;

    assign full    = (cnt == CNT_MAX);
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4: occupancy never exceeds the configured depth
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
    // R7: a push into a full queue leaves the occupancy unchanged
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    hr_state_t state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            HR_EMPTY: if (load) state_n = HR_FULL;
            HR_FULL:  if (take && !load) state_n = HR_EMPTY;
            default:  state_n = HR_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HR_EMPTY;
            data  <= '0;
        end else begin
            state <= state_n;
            if (load) data <= load_data;
        end
    end

    always_comb begin
        full = (state == HR_FULL);
    end

    // R8: a byte is loaded only into an empty register or one being taken
    p_load_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && state == HR_FULL) |-> take);
    // R4: the serializer takes only a present byte
    p_take_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (state == HR_FULL));
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              unit_en,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              busy,
    output logic              txd
);
    localparam int TW = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int BW = $clog2(DATA_W);
    localparam logic [TW-1:0] TC_LAST  = TW'(OVS - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

    sh_state_t         state, state_n;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic              last_tick;

    assign last_tick = baud_tick && (tcnt == TC_LAST);

    always_comb begin
        state_n = state;
        take    = 1'b0;
        unique case (state)
            SH_IDLE: if (unit_en && hold_full) begin
                take    = 1'b1;
                state_n = SH_START;
            end
            SH_START: if (last_tick) state_n = SH_DATA;
            SH_DATA:  if (last_tick && bidx == BIT_LAST) state_n = SH_STOP;
            SH_STOP:  if (last_tick) state_n = SH_IDLE;
            default:  state_n = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            sh    <= '0;
        end else begin
            state <= state_n;
            if (state == SH_IDLE)  tcnt <= '0;
            else if (baud_tick)    tcnt <= last_tick ? '0 : tcnt + 1'b1;
            if (state != SH_DATA)  bidx <= '0;
            else if (last_tick)    bidx <= bidx + 1'b1;
            if (take)              sh <= hold_data;
            else if (state == SH_DATA && last_tick) sh <= {1'b0, sh[DATA_W-1:1]};
        end
    end

    always_comb begin
        busy = (state != SH_IDLE);
        unique case (state)
            SH_START: txd = 1'b0;
            SH_DATA:  txd = sh[0];
            default:  txd = 1'b1;
        endcase
    end

    // R5: no frame starts while the unit is disabled
    p_no_start_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_IDLE && !unit_en) |=> (state == SH_IDLE));
    // R5: a frame in progress is never cut short, enabled or not
    p_no_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_START || state == SH_DATA) |=> (state != SH_IDLE));
    // R3: bit timing advances only on baud ticks
    p_tick_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SH_IDLE && !baud_tick) |=> $stable(tcnt));
endmodule

// File: rtl/uart_tx_gated.sv
module uart_tx_gated
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       unit_en,
    input  logic       fifo_mode,
    input  logic       baud_tick,
    output logic       txd,
    output logic       thr_empty,
    output logic       tx_idle,
    output logic       ovf_flag
);
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [DATA_W-1:0] fifo_rdata, hold_data, load_data;
    logic              hold_full, hold_load, take, busy, can_load, drop;

    assign can_load  = !hold_full || take;
    assign fifo_push = wr_en && fifo_mode;
    assign fifo_pop  = fifo_mode && can_load && !fifo_empty;
    assign hold_load = fifo_mode ? fifo_pop : (wr_en && can_load);
    assign load_data = fifo_mode ? fifo_rdata : wr_data;
    assign drop      = wr_en && (fifo_mode ? fifo_full : !can_load);

    uart_txq_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(wr_data),
        .pop(fifo_pop), .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full)
    );

    uart_tx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .load(hold_load), .load_data(load_data),
        .take(take), .full(hold_full), .data(hold_data)
    );

    uart_tx_shifter #(.OVS(OVS)) u_shift (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .unit_en(unit_en),
        .hold_full(hold_full), .hold_data(hold_data), .take(take),
        .busy(busy), .txd(txd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ovf_flag <= 1'b0;
        else if (drop) ovf_flag <= 1'b1;
    end

    always_comb begin
        thr_empty = !hold_full;
        tx_idle   = fifo_empty && !hold_full && !busy;
    end

    // R9: the overflow flag is sticky
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);
    // R7: a write into a full FIFO raises the flag
    p_ovf_fifo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_mode && fifo_full) |=> ovf_flag);
    // R2: a FIFO-mode write with room is kept even while disabled
    p_keep_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fifo_mode && !fifo_full && !unit_en) |=> !tx_idle);
endmodule

// File: tb/sim_uart_tx_gated.sv
module sim_uart_tx_gated;
    localparam int DEPTH = 4;
    localparam int OVS   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       unit_en = 1'b0;
    logic       fifo_mode = 1'b1;
    logic       baud_tick = 1'b1;
    logic       txd, thr_empty, tx_idle, ovf_flag;

    int errors = 0;
    int checks = 0;
    int got = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    uart_tx_gated #(.DEPTH(DEPTH), .OVS(OVS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .unit_en(unit_en), .fifo_mode(fifo_mode), .baud_tick(baud_tick),
        .txd(txd), .thr_empty(thr_empty), .tx_idle(tx_idle), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b, input bit expect_sent);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        if (expect_sent) exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_got(input int n);
        for (int i = 0; i < 3000 && got < n; i++) @(negedge clk);
    endtask

    // monitor: samples each bit at its centre and compares with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] b;
                repeat (OVS/2 - 1) @(negedge clk);
                chk(txd === 1'b0, "R3 start", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (OVS) @(negedge clk);
                    b[i] = txd;
                end
                repeat (OVS) @(negedge clk);
                chk(txd === 1'b1, "R3 stop", txd, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected byte", b, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(b == e, "R3/R4 byte", b, e);
                end
                got++;
            end
        end
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd && thr_empty && tx_idle && !ovf_flag, "R1 reset state",
            {txd, thr_empty, tx_idle, ovf_flag}, 4'b1110);

        // R2: queue while disabled, nothing goes out
        wr(8'hA5, 1); wr(8'h3C, 1); wr(8'h01, 1);
        hi = 1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) hi = 0;
        end
        chk(hi == 1 && got == 0, "R1 line quiet while disabled", got, 0);
        chk(!tx_idle, "R10 tx_idle low with queued data", tx_idle, 0);
        chk(!thr_empty, "R4 holding register loaded from FIFO", thr_empty, 0);

        unit_en = 1'b1;
        wait_got(3);
        chk(got == 3, "R2 queued bytes sent after enable", got, 3);
        repeat (10) @(negedge clk);
        chk(tx_idle && thr_empty, "R10 idle after drain", {tx_idle, thr_empty}, 2'b11);

        // R5/R6: disable mid-frame
        wr(8'hF0, 1); wr(8'h0F, 1); wr(8'h81, 1);
        while (txd !== 1'b0) @(negedge clk);
        repeat (10) @(negedge clk);
        unit_en = 1'b0;
        repeat (150) @(negedge clk);
        chk(got == 4, "R5 current frame completes, no next frame", got, 4);
        chk(!tx_idle, "R6 remaining bytes kept", tx_idle, 0);
        unit_en = 1'b1;
        wait_got(6);
        chk(got == 6, "R6 resume after re-enable", got, 6);
        repeat (10) @(negedge clk);

        // R7: overflow in FIFO mode (DEPTH + holding register accepted)
        unit_en = 1'b0;
        for (int i = 0; i < DEPTH + 1; i++) wr(8'h10 + 8'(i), 1);
        chk(!ovf_flag, "R4 capacity DEPTH+1 without overflow", ovf_flag, 0);
        wr(8'hEE, 0);
        chk(ovf_flag, "R7 overflow flag on full write", ovf_flag, 1);
        unit_en = 1'b1;
        wait_got(6 + DEPTH + 1);
        repeat (10) @(negedge clk);
        chk(got == 6 + DEPTH + 1 && exp_q.size() == 0, "R7 dropped byte not sent",
            got, 6 + DEPTH + 1);
        chk(ovf_flag, "R9 flag sticky", ovf_flag, 1);

        // R9: reset clears the flag
        unit_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ovf_flag, "R9 cleared by reset", ovf_flag, 0);

        // R8: non-FIFO mode
        fifo_mode = 1'b0;
        wr(8'h55, 1);
        chk(!ovf_flag && !thr_empty, "R8 first write held", {ovf_flag, thr_empty}, 2'b00);
        wr(8'h99, 0);
        chk(ovf_flag, "R8 second write dropped and flagged", ovf_flag, 1);
        unit_en = 1'b1;
        wait_got(6 + DEPTH + 2);
        repeat (60) @(negedge clk);
        chk(got == 6 + DEPTH + 2 && exp_q.size() == 0, "R8 only held byte sent",
            got, 6 + DEPTH + 2);
        chk(tx_idle && thr_empty, "R10 idle at end", {tx_idle, thr_empty}, 2'b11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule